// File: doc/BRIEF.md
# Redundant Subnet Injection Controller

This block sits on the injection side of a network interface that attaches to four disjoint sub-networks, one router in each. Every packet goes into exactly one subnet. For each new packet the controller picks the lowest-numbered subnet that is still usable, writes that subnet's 2-bit number into the header flit, and passes the rest of the packet through unchanged. Every flit of the packet stays on that subnet until the tail flit has been handed on.

The controller keeps a state for each subnet: active, congested or faulty. A congestion flag from a subnet parks it until the flag drops. A route-failure report, meaning that neither turn model can make progress there, retires the subnet until reset. Within the chosen subnet the packet uses the north-last turn model. If the subnet signals that the next hop on that path is unsafe, the packet uses the south-last model instead. When no subnet is usable, the block raises a flag and holds new packets back.

The flit path is a valid/ready stream. A flit moves on a cycle where valid and ready are both high. `in_ready` follows `out_ready` and `out_valid` follows `in_valid` in the same cycle, with no storage in between. A packet that has not yet started while no subnet is usable is held: `in_ready` and `out_valid` are both low and the source must keep its header. The per-subnet flags and the selection outputs are plain level signals.

Top module: `mnet_inject_ctrl`

## Requirements
- R1: After reset all four subnets are active, no packet is in progress, `sel_subnet` is 0, `sel_mode` is 0 and `all_unusable` is 0.
- R2: Between packets, `sel_subnet` is the lowest index whose state is active.
- R3: On the header flit (the first flit after reset or after a flit with `in_last`=1), `out_data[1:0]` carries the selected subnet number and `out_data[FLIT_W-1:2]` equals `in_data[FLIT_W-1:2]`. Every later flit passes through with all bits unchanged.
- R4: Once a header flit has been accepted without `in_last`, `sel_subnet` and `sel_mode` keep the values the header was sent with, whatever the flags do, until a flit with `in_last`=1 is accepted.
- R5: Between packets, `sel_mode` is 0 (north-last) when `unsafe_flag` of the selected subnet is 0, and 1 (south-last) when it is 1.
- R6: A cycle with `fail_valid`=1 marks subnet `fail_sub` faulty from the next cycle on. It stays faulty until reset.
- R7: An active subnet whose `cong_flag` is 1 at a clock edge becomes congested. A congested subnet whose `cong_flag` is 0 at a clock edge becomes active again.
- R8: When no subnet is active, `all_unusable` is 1. While no packet is in progress, `in_ready` and `out_valid` are then 0. A packet already in progress keeps flowing.
- R9: Whenever a flit is allowed to pass, `in_ready` equals `out_ready`, `out_valid` equals `in_valid`, and `out_last` equals `in_last`, all in the same cycle.
- R10: A failure report for a congested subnet makes it faulty, and clearing its congestion flag afterwards does not bring it back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Upstream flit valid |
| in_ready | output | 1 | Upstream flit accepted |
| in_data | input | FLIT_W | Upstream flit |
| in_last | input | 1 | Upstream flit is the tail |
| out_valid | output | 1 | Flit toward the routers is valid |
| out_ready | input | 1 | Router side can take a flit |
| out_data | output | FLIT_W | Flit with the subnet number written into the header |
| out_last | output | 1 | Outgoing flit is the tail |
| cong_flag | input | NUM_SUB | Per-subnet congestion indication |
| unsafe_flag | input | NUM_SUB | Per-subnet flag: next hop on the north-last path is unsafe |
| fail_valid | input | 1 | Route-failure report strobe |
| fail_sub | input | ID_W | Subnet that failed to route |
| sel_subnet | output | ID_W | Subnet for the current or next packet |
| sel_mode | output | 1 | Turn model: 0 north-last, 1 south-last |
| all_unusable | output | 1 | No subnet is active |

## Verification
The bench builds the block with its default parameters: four subnets, giving a 2-bit identifier, and 16-bit flits. With four subnets, a handful of congestion toggles or failure reports is enough to exhaust the whole escalation order, so the state where every subnet is unusable comes up often. The 16-bit flit leaves 14 payload bits above the identifier field, which lets the bench confirm that the header rewrite touches only the low two bits. Random flag churn in the middle of packets exercises the lock on subnet and mode. Periodic resets clear faulty subnets so that the random runs keep reaching new selections.

// File: rtl/mnet_pkg.sv
package mnet_pkg;
  typedef enum logic [1:0] {
    SN_ACTIVE    = 2'd0,
    SN_FAULTY    = 2'd1,
    SN_CONGESTED = 2'd2
  } sn_state_e;

  typedef enum logic {
    RM_NORTH_LAST = 1'b0,
    RM_SOUTH_LAST = 1'b1
  } rmode_e;
endpackage

// File: rtl/mnet_sub_state.sv
module mnet_sub_state
  import mnet_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cong,
  input  logic       fail,
  output logic [1:0] state_o
);
  sn_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (fail)                                st_d = SN_FAULTY;
    else if (st_q == SN_ACTIVE && cong)      st_d = SN_CONGESTED;
    else if (st_q == SN_CONGESTED && !cong)  st_d = SN_ACTIVE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= SN_ACTIVE;
    else        st_q <= st_d;
  end

  assign state_o = st_q;
endmodule

// File: rtl/mnet_sub_pick.sv
module mnet_sub_pick #(
  parameter int NUM_SUB = 4,
  localparam int ID_W = (NUM_SUB > 1) ? $clog2(NUM_SUB) : 1
) (
  input  logic [NUM_SUB-1:0] usable,
  output logic [ID_W-1:0]    idx,
  output logic               any
);
  always_comb begin
    idx = '0;
    for (int s = NUM_SUB - 1; s >= 0; s--) begin
      if (usable[s]) idx = ID_W'(s);
    end
    any = |usable;
  end
endmodule

// File: rtl/mnet_flit_tag.sv
module mnet_flit_tag #(
  parameter int FLIT_W = 16,
  parameter int ID_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [FLIT_W-1:0] in_data,
  input  logic              in_last,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [FLIT_W-1:0] out_data,
  output logic              out_last,
  input  logic [ID_W-1:0]   pick_idx,
  input  logic              pick_mode,
  input  logic              pick_any,
  output logic [ID_W-1:0]   sel_idx,
  output logic              sel_mode,
  output logic              mid_o
);
  logic            mid_q;
  logic [ID_W-1:0] lock_idx_q;
  logic            lock_mode_q;
  logic            pass, fire;

  assign pass      = mid_q | pick_any;
  assign in_ready  = out_ready & pass;
  assign out_valid = in_valid & pass;
  assign fire      = in_valid & in_ready;
  assign sel_idx   = mid_q ? lock_idx_q  : pick_idx;
  assign sel_mode  = mid_q ? lock_mode_q : pick_mode;
  assign out_data  = mid_q ? in_data : {in_data[FLIT_W-1:ID_W], sel_idx};
  assign out_last  = in_last;
  assign mid_o     = mid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mid_q       <= 1'b0;
      lock_idx_q  <= '0;
      lock_mode_q <= 1'b0;
    end else if (fire) begin
      if (in_last) begin
        mid_q <= 1'b0;
      end else if (!mid_q) begin
        mid_q       <= 1'b1;
        lock_idx_q  <= pick_idx;
        lock_mode_q <= pick_mode;
      end
    end
  end
endmodule

// File: rtl/mnet_inject_ctrl.sv
module mnet_inject_ctrl
  import mnet_pkg::*;
#(
  parameter int NUM_SUB = 4,
  parameter int FLIT_W  = 16,
  localparam int ID_W = (NUM_SUB > 1) ? $clog2(NUM_SUB) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [FLIT_W-1:0]  in_data,
  input  logic               in_last,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [FLIT_W-1:0]  out_data,
  output logic               out_last,
  input  logic [NUM_SUB-1:0] cong_flag,
  input  logic [NUM_SUB-1:0] unsafe_flag,
  input  logic               fail_valid,
  input  logic [ID_W-1:0]    fail_sub,
  output logic [ID_W-1:0]    sel_subnet,
  output logic               sel_mode,
  output logic               all_unusable
);
  logic [NUM_SUB-1:0][1:0] sub_st;
  logic [NUM_SUB-1:0]      usable;
  logic [ID_W-1:0]         pick_idx;
  logic                    pick_any;
  logic                    pick_mode;
  logic                    mid_pkt;

  for (genvar g = 0; g < NUM_SUB; g++) begin : g_sub
    logic hit;
    assign hit = fail_valid && (fail_sub == ID_W'(g));
    mnet_sub_state u_state (
      .clk     (clk),
      .rst_n   (rst_n),
      .cong    (cong_flag[g]),
      .fail    (hit),
      .state_o (sub_st[g])
    );
    assign usable[g] = (sub_st[g] == SN_ACTIVE);
  end

  mnet_sub_pick #(.NUM_SUB(NUM_SUB)) u_pick (
    .usable (usable),
    .idx    (pick_idx),
    .any    (pick_any)
  );

  assign pick_mode    = unsafe_flag[pick_idx] ? RM_SOUTH_LAST : RM_NORTH_LAST;
  assign all_unusable = !pick_any;

  mnet_flit_tag #(.FLIT_W(FLIT_W), .ID_W(ID_W)) u_tag (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .in_last   (in_last),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_last  (out_last),
    .pick_idx  (pick_idx),
    .pick_mode (pick_mode),
    .pick_any  (pick_any),
    .sel_idx   (sel_subnet),
    .sel_mode  (sel_mode),
    .mid_o     (mid_pkt)
  );
endmodule

// File: rtl/mnet_inject_ctrl_chk.sv
module mnet_inject_ctrl_chk #(
  parameter int NUM_SUB = 4,
  parameter int FLIT_W  = 16,
  localparam int ID_W = (NUM_SUB > 1) ? $clog2(NUM_SUB) : 1
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic                    in_ready,
  input logic                    in_last,
  input logic                    out_valid,
  input logic                    out_ready,
  input logic                    out_last,
  input logic [NUM_SUB-1:0]      cong_flag,
  input logic                    fail_valid,
  input logic [ID_W-1:0]         fail_sub,
  input logic [ID_W-1:0]         sel_subnet,
  input logic                    sel_mode,
  input logic                    all_unusable,
  input logic                    mid_pkt,
  input logic [NUM_SUB-1:0][1:0] sub_st
);
  assert_lock_subnet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !out_last) |=> sel_subnet == $past(sel_subnet));

  assert_lock_mode_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !out_last) |=> sel_mode == $past(sel_mode));

  assert_stall_new_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (all_unusable && !mid_pkt) |-> (!in_ready && !out_valid));

  assert_pass_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |-> (out_valid && out_ready && out_last == in_last));

  for (genvar s = 0; s < NUM_SUB; s++) begin : g_chk
    assert_sticky_fault_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (sub_st[s] == 2'd1) |=> (sub_st[s] == 2'd1));

    assert_mark_fault_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (fail_valid && fail_sub == ID_W'(s)) |=> (sub_st[s] == 2'd1));

    assert_park_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (sub_st[s] == 2'd0 && cong_flag[s] && !(fail_valid && fail_sub == ID_W'(s)))
      |=> (sub_st[s] == 2'd2));

    assert_unpark_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (sub_st[s] == 2'd2 && !cong_flag[s] && !(fail_valid && fail_sub == ID_W'(s)))
      |=> (sub_st[s] == 2'd0));
  end
endmodule

bind mnet_inject_ctrl mnet_inject_ctrl_chk #(.NUM_SUB(NUM_SUB), .FLIT_W(FLIT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_valid     (in_valid),
  .in_ready     (in_ready),
  .in_last      (in_last),
  .out_valid    (out_valid),
  .out_ready    (out_ready),
  .out_last     (out_last),
  .cong_flag    (cong_flag),
  .fail_valid   (fail_valid),
  .fail_sub     (fail_sub),
  .sel_subnet   (sel_subnet),
  .sel_mode     (sel_mode),
  .all_unusable (all_unusable),
  .mid_pkt      (mid_pkt),
  .sub_st       (sub_st)
);

// File: tb/mnet_inject_ctrl_test.sv
module mnet_inject_ctrl_test;
  localparam int NS = 4;
  localparam int FW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_last = 1'b0, out_ready = 1'b1, fail_valid = 1'b0;
  logic [FW-1:0] in_data = '0;
  logic [NS-1:0] cong_flag = '0, unsafe_flag = '0;
  logic [1:0] fail_sub = '0;
  logic in_ready, out_valid, out_last, sel_mode, all_unusable;
  logic [FW-1:0] out_data;
  logic [1:0] sel_subnet;

  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  mnet_inject_ctrl #(.NUM_SUB(NS), .FLIT_W(FW)) uut (.*);

  // reference model: 0 active, 1 faulty, 2 congested
  logic [1:0] ms [NS];
  logic m_mid, m_lmode;
  logic [1:0] m_lsub;

  function automatic logic [2:0] mpick();
    logic [2:0] r = 3'b000;
    for (int s = NS - 1; s >= 0; s--) if (ms[s] == 2'd0) r = {1'b1, 2'(s)};
    return r;
  endfunction
  function automatic logic [1:0] e_sub();
    logic [2:0] p = mpick();
    return m_mid ? m_lsub : p[1:0];
  endfunction
  function automatic logic e_mode();
    logic [2:0] p = mpick();
    return m_mid ? m_lmode : unsafe_flag[p[1:0]];
  endfunction
  function automatic logic e_pass();
    logic [2:0] p = mpick();
    return m_mid | p[2];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < NS; s++) ms[s] <= 2'd0;
      m_mid <= 1'b0; m_lsub <= '0; m_lmode <= 1'b0;
    end else begin
      for (int s = 0; s < NS; s++) begin
        if (fail_valid && fail_sub == 2'(s)) ms[s] <= 2'd1;
        else if (ms[s] == 2'd0 && cong_flag[s]) ms[s] <= 2'd2;
        else if (ms[s] == 2'd2 && !cong_flag[s]) ms[s] <= 2'd0;
      end
      if (in_valid && out_ready && e_pass()) begin
        if (in_last) m_mid <= 1'b0;
        else if (!m_mid) begin
          m_mid <= 1'b1; m_lsub <= e_sub(); m_lmode <= e_mode();
        end
      end
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic compare();
    logic [2:0] p = mpick();
    logic stall = !p[2] && !m_mid;
    chk(m_mid ? "R4 subnet" : "R2 subnet", 32'(sel_subnet), 32'(e_sub()));
    chk(m_mid ? "R4 mode" : "R5 mode", 32'(sel_mode), 32'(e_mode()));
    chk("R8 flag", 32'(all_unusable), 32'(!p[2]));
    chk(stall ? "R8 in_ready" : "R9 in_ready", 32'(in_ready), 32'(out_ready && e_pass()));
    chk(stall ? "R8 out_valid" : "R9 out_valid", 32'(out_valid), 32'(in_valid && e_pass()));
    chk("R9 out_last", 32'(out_last), 32'(in_last));
    if (in_valid && e_pass())
      chk("R3 data", 32'(out_data),
          32'(m_mid ? in_data : {in_data[FW-1:2], e_sub()}));
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    #1 compare();
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    #1;
  endtask

  initial begin
    int unused;
    unused = $urandom(32'd4711);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 subnet", 32'(sel_subnet), 0);
    chk("R1 mode", 32'(sel_mode), 0);
    chk("R1 flag", 32'(all_unusable), 0);
    chk("R1 in_ready", 32'(in_ready), 1);
    compare();

    // R7 park and unpark
    cong_flag = 4'b0001; step();
    chk("R7 parked", 32'(sel_subnet), 1);
    cong_flag = 4'b0000; step();
    chk("R7 back", 32'(sel_subnet), 0);

    // R10 failure while congested
    cong_flag = 4'b0010; step();
    fail_valid = 1'b1; fail_sub = 2'd1; step();
    fail_valid = 1'b0; cong_flag = 4'b0001; step();
    chk("R10 stays faulty", 32'(sel_subnet), 2);

    // R6 sticky until reset
    fail_valid = 1'b1; fail_sub = 2'd0; step();
    fail_valid = 1'b0; cong_flag = 4'b0000; step(); step();
    chk("R6 sticky", 32'(sel_subnet), 2);
    unsafe_flag = 4'b0100; #1;
    chk("R5 south-last", 32'(sel_mode), 1);
    unsafe_flag = 4'b0000;
    do_reset();
    chk("R6 cleared by reset", 32'(sel_subnet), 0);

    // R4 lock mid-packet, R8 stall
    in_valid = 1'b1; in_last = 1'b0; in_data = 16'hABCD; step();
    cong_flag = 4'b1111; step();
    chk("R4 held subnet", 32'(sel_subnet), 0);
    chk("R8 flow mid-packet", 32'(in_ready), 1);
    in_last = 1'b1; step();
    chk("R8 stalled", 32'(in_ready), 0);
    chk("R8 no valid", 32'(out_valid), 0);
    chk("R8 flag set", 32'(all_unusable), 1);
    cong_flag = 4'b0000; step();
    chk("R8 resumed", 32'(in_ready), 1);

    // random phase
    for (int c = 0; c < 6000; c++) begin
      if (c % 400 == 399) begin
        in_valid = 1'b0; fail_valid = 1'b0;
        do_reset();
      end
      in_valid  = ($urandom % 4) != 0;
      out_ready = ($urandom % 4) != 0;
      in_last   = ($urandom % 3) == 0;
      in_data   = 16'($urandom);
      for (int s = 0; s < NS; s++) if ($urandom % 8 == 0) cong_flag[s] = ~cong_flag[s];
      unsafe_flag = 4'($urandom);
      fail_valid = ($urandom % 70) == 0;
      fail_sub   = 2'($urandom);
      step();
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R9 watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule